// File: doc/BRIEF.md
# Multi-Chain Scan Self-Test Controller

This block runs a logic self-test over a full-scan design split into many parallel scan chains of equal length. A Galois LFSR produces pseudo-random bits, and a small XOR network turns its state into one distinct bit per chain. Without that network, neighbouring chains would receive the same stream shifted by a cycle or two. The controller shifts a pattern into every chain at once. It then drops scan-enable for one functional clock so the logic under test captures its response. After that it shifts again. During every shift after the first, the bits falling out of the chains are folded into a multiple-input signature register with one input per chain, while the next pattern enters at the same time.

Once the requested number of patterns has been captured, a last shift pass runs with the chain inputs held at zero. This pass only drains the final responses into the signature register. The block then raises its completion flag and holds the signature until the next start. Software or an external tester compares that signature with a known-good value.

Top module: `scanBistTop`

## Requirements
- R1: After reset, scan-enable is low, the completion flag is low and the signature is all zeros.
- R2: A start accepted with a pattern count P greater than zero produces P+1 shift passes. Each pass holds scan-enable high for exactly CHAIN_LEN consecutive cycles. Each of the first P passes is followed by exactly one cycle with scan-enable low, which is the capture clock.
- R3: A start seeds the LFSR to LFSR_SEED. During a loading pass, chain c receives lfsr[a] XOR lfsr[b], where a = c mod LFSR_W and b = (a + 1 + c div LFSR_W) mod LFSR_W. After each such cycle the LFSR advances by the Galois rule: the state shifts right one place and is XORed with LFSR_TAPS when its bit 0 was 1.
- R4: A start clears the signature to zero. In each shift cycle of passes 2 to P+1, the signature becomes (sig >> 1) XOR (sig[0] ? MISR_TAPS : 0) XOR chainOut, with bit c of chainOut coming from chain c. The signature never changes in any other cycle.
- R5: The completion flag rises exactly P*(CHAIN_LEN+1)+CHAIN_LEN clock edges after the edge that accepted start, and it stays low before that.
- R6: A start with pattern count zero sets the completion flag on the next edge and leaves the signature at zero, with no shifting.
- R7: During the final drain pass, and whenever scan-enable is low, every chain input is driven to zero.
- R8: While a test is running, start is ignored: the schedule and the final signature are unchanged.
- R9: A new start after completion reseeds both registers, so repeating a test with the same count gives the same signature.
- R10: While start stays low, the completion flag and the signature hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a test when idle or finished |
| patCount | input | CNT_W | Number of patterns to apply, sampled with start |
| scanEn | output | 1 | High to shift the chains, low for a functional capture |
| chainIn | output | NUM_CHAINS | Serial input bit for each chain |
| chainOut | input | NUM_CHAINS | Serial output bit from each chain |
| done | output | 1 | Test finished; signature valid |
| signature | output | NUM_CHAINS | Compacted response signature |

## Verification
An off-by-one in the shift counter shows up at once in the length of the first scan-enable pulse. It also moves the completion flag by P+1 cycles. A wrong LFSR step or phase-shifter tap corrupts chainIn on the very first shift cycle, well before any signature exists. Errors in the drain or unload gating, or in the MISR feedback, appear only in the final signature, about (P+1)*CHAIN_LEN cycles later. The bench therefore compares chainIn and scan-enable every cycle against its own reference, and compares the signature at the end.

// File: rtl/scanBistPkg.sv
package scanBistPkg;

  // Strobes from the sequencer to the pattern/signature datapath.
  typedef struct packed {
    logic seed;      // reload LFSR seed, clear signature
    logic lfsrStep;  // advance the pattern source
    logic misrStep;  // fold chain outputs into the signature
    logic drive;     // present phase-shifted bits on the chain inputs
  } bistStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CAPT  = 2'd2,
    ST_FIN   = 2'd3
  } bistState_t;

endpackage

// File: rtl/scanBistCtrl.sv
module scanBistCtrl
  import scanBistPkg::*;
#(
  parameter int CHAIN_LEN = 200,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] patCount,
  output bistStrobe_t      strobe,
  output logic             scanEn,
  output logic             done
);

  localparam int BIT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAIN_LEN - 1);

  bistState_t       state;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] patLeft;
  logic             loadOn;
  logic             unloadOn;
  logic             accept;

  assign accept = start && (state == ST_IDLE || state == ST_FIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      patLeft  <= '0;
      loadOn   <= 1'b0;
      unloadOn <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_FIN: begin
          if (accept) begin
            bitCnt   <= '0;
            patLeft  <= patCount;
            unloadOn <= 1'b0;
            if (patCount == '0) begin
              loadOn <= 1'b0;
              state  <= ST_FIN;
            end else begin
              loadOn <= 1'b1;
              state  <= ST_SHIFT;
            end
          end
        end
        ST_SHIFT: begin
          if (bitCnt == LAST_BIT) begin
            bitCnt <= '0;
            if (loadOn) begin
              patLeft <= patLeft - 1'b1;
              state   <= ST_CAPT;
            end else begin
              state <= ST_FIN;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_CAPT: begin
          unloadOn <= 1'b1;
          loadOn   <= (patLeft != '0);
          state    <= ST_SHIFT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.seed     = accept;
    strobe.lfsrStep = (state == ST_SHIFT) && loadOn;
    strobe.misrStep = (state == ST_SHIFT) && unloadOn;
    strobe.drive    = (state == ST_SHIFT) && loadOn;
  end

  assign scanEn = (state == ST_SHIFT);
  assign done   = (state == ST_FIN);

endmodule

// File: rtl/scanBistPath.sv
module scanBistPath
  import scanBistPkg::*;
#(
  parameter int                    NUM_CHAINS = 25,
  parameter int                    LFSR_W     = 16,
  parameter logic [LFSR_W-1:0]     LFSR_TAPS  = 16'hB400,
  parameter logic [LFSR_W-1:0]     LFSR_SEED  = 16'hACE1,
  parameter logic [NUM_CHAINS-1:0] MISR_TAPS  = 25'h1200000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bistStrobe_t           strobe,
  input  logic [NUM_CHAINS-1:0] chainOut,
  output logic [NUM_CHAINS-1:0] chainIn,
  output logic [NUM_CHAINS-1:0] signature
);

  logic [LFSR_W-1:0]     lfsr;
  logic [LFSR_W-1:0]     lfsrNext;
  logic [NUM_CHAINS-1:0] misr;
  logic [NUM_CHAINS-1:0] misrNext;
  logic [NUM_CHAINS-1:0] phased;

  assign lfsrNext = (lfsr >> 1) ^ (lfsr[0] ? LFSR_TAPS : '0);
  assign misrNext = (misr >> 1) ^ (misr[0] ? MISR_TAPS : '0) ^ chainOut;

  // Phase shifter: two LFSR taps per chain, spread so no two chains match.
  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_phase
    localparam int TAP_A = c % LFSR_W;
    localparam int TAP_B = (TAP_A + 1 + c / LFSR_W) % LFSR_W;
    assign phased[c] = lfsr[TAP_A] ^ lfsr[TAP_B];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr <= LFSR_SEED;
      misr <= '0;
    end else if (strobe.seed) begin
      lfsr <= LFSR_SEED;
      misr <= '0;
    end else begin
      if (strobe.lfsrStep) lfsr <= lfsrNext;
      if (strobe.misrStep) misr <= misrNext;
    end
  end

  assign chainIn   = strobe.drive ? phased : '0;
  assign signature = misr;

endmodule

// File: rtl/scanBistTop.sv
module scanBistTop
  import scanBistPkg::*;
#(
  parameter int                    CHAIN_LEN  = 200,
  parameter int                    NUM_CHAINS = 25,
  parameter int                    CNT_W      = 16,
  parameter int                    LFSR_W     = 16,
  parameter logic [LFSR_W-1:0]     LFSR_TAPS  = 16'hB400,
  parameter logic [LFSR_W-1:0]     LFSR_SEED  = 16'hACE1,
  parameter logic [NUM_CHAINS-1:0] MISR_TAPS  = 25'h1200000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [CNT_W-1:0]      patCount,
  output logic                  scanEn,
  output logic [NUM_CHAINS-1:0] chainIn,
  input  logic [NUM_CHAINS-1:0] chainOut,
  output logic                  done,
  output logic [NUM_CHAINS-1:0] signature
);

  bistStrobe_t strobe;

  scanBistCtrl #(
    .CHAIN_LEN(CHAIN_LEN),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .patCount(patCount),
    .strobe  (strobe),
    .scanEn  (scanEn),
    .done    (done)
  );

  scanBistPath #(
    .NUM_CHAINS(NUM_CHAINS),
    .LFSR_W    (LFSR_W),
    .LFSR_TAPS (LFSR_TAPS),
    .LFSR_SEED (LFSR_SEED),
    .MISR_TAPS (MISR_TAPS)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .chainOut (chainOut),
    .chainIn  (chainIn),
    .signature(signature)
  );

endmodule

// File: rtl/scanBistChecker.sv
module scanBistChecker #(
  parameter int CHAIN_LEN  = 200,
  parameter int NUM_CHAINS = 25,
  parameter int CNT_W      = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  start,
  input logic [CNT_W-1:0]      patCount,
  input logic                  scanEn,
  input logic [NUM_CHAINS-1:0] chainIn,
  input logic                  done,
  input logic [NUM_CHAINS-1:0] signature
);

  localparam int RUN_W = $clog2(CHAIN_LEN + 2) + 1;

  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (scanEn) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  // R2: no shift pass runs longer than one chain length
  always_comb begin
    if (rstN) begin
      a_r2_shift_window: assert (runLen <= RUN_W'(CHAIN_LEN))
        else $error("shift pass longer than chain length");
    end
  end

  // R2: a capture is a single cycle unless the test has ended
  a_r2_single_capture: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(scanEn) && !done) |=> scanEn);

  // R7: chain inputs are quiet whenever the chains are not shifting
  a_r7_quiet_inputs: assert property (@(posedge clk) disable iff (!rstN)
    (chainIn != '0) |-> scanEn);

  // R4: the signature only moves on shift cycles or a reseed
  a_r4_sig_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!scanEn && !start) |=> $stable(signature));

  // R10: completion and signature hold while start is low
  a_r10_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(signature)));

  // R6: zero-pattern start completes at once with a cleared signature
  a_r6_zero_count: assert property (@(posedge clk) disable iff (!rstN)
    (done && start && patCount == '0) |=> (done && signature == '0));

endmodule

bind scanBistTop scanBistChecker #(
  .CHAIN_LEN (CHAIN_LEN),
  .NUM_CHAINS(NUM_CHAINS),
  .CNT_W     (CNT_W)
) chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .patCount (patCount),
  .scanEn   (scanEn),
  .chainIn  (chainIn),
  .done     (done),
  .signature(signature)
);

// File: tb/scanBistTop_test.sv
module scanBistTop_test;

  localparam int              CL    = 200;
  localparam int              NC    = 25;
  localparam int              CW    = 16;
  localparam int              LW    = 16;
  localparam logic [LW-1:0]   LTAPS = 16'hB400;
  localparam logic [LW-1:0]   LSEED = 16'hACE1;
  localparam logic [NC-1:0]   MTAPS = 25'h1200000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] patCount = '0;
  logic          scanEn;
  logic [NC-1:0] chainIn;
  logic [NC-1:0] chainOut;
  logic          done;
  logic [NC-1:0] signature;
  logic          scramble = 1'b0;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  logic [CL-1:0] standIn  [NC];
  logic [CL-1:0] refChain [NC];

  always #2 clk = ~clk;

  scanBistTop uut (
    .clk(clk), .rstN(rstN), .start(start), .patCount(patCount),
    .scanEn(scanEn), .chainIn(chainIn), .chainOut(chainOut),
    .done(done), .signature(signature)
  );

  // Stand-in scan chains and logic under test.
  always_comb begin
    for (int c = 0; c < NC; c++) chainOut[c] = standIn[c][CL-1];
  end

  always @(posedge clk) begin
    for (int c = 0; c < NC; c++) begin
      if (scramble) begin
        for (int b = 0; b < CL; b++) standIn[c][b] <= 1'($urandom);
      end else if (scanEn) begin
        standIn[c] <= {standIn[c][CL-2:0], chainIn[c]};
      end else begin
        standIn[c] <= {standIn[c][CL-2:0], standIn[c][CL-1]} ^ standIn[(c + 1) % NC];
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      mismatched = mismatched + 1;
      compared = compared + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic [LW-1:0] lfsrAdv(input logic [LW-1:0] s);
    return (s >> 1) ^ (s[0] ? LTAPS : '0);
  endfunction

  function automatic logic [NC-1:0] phaseOf(input logic [LW-1:0] s);
    logic [NC-1:0] r;
    for (int c = 0; c < NC; c++) begin
      int a = c % LW;
      int b = (a + 1 + c / LW) % LW;
      r[c] = s[a] ^ s[b];
    end
    return r;
  endfunction

  function automatic logic [NC-1:0] misrAdv(input logic [NC-1:0] m, input logic [NC-1:0] d);
    return (m >> 1) ^ (m[0] ? MTAPS : '0) ^ d;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared = compared + 1;
    if (!ok) begin
      mismatched = mismatched + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Runs one test with a full cycle-by-cycle reference; returns the signature seen.
  task automatic runTest(input int pats, input int glitchAt, output logic [NC-1:0] sigOut);
    int total = pats * (CL + 1) + CL;
    logic [LW-1:0] rl = LSEED;
    logic [NC-1:0] rm = '0;
    bit enOk = 1, ldOk = 1, flOk = 1, dnOk = 1;
    logic [63:0] enA = 0, enE = 0, ldA = 0, ldE = 0, flA = 0;
    int dnAt = -1;
    for (int c = 0; c < NC; c++) refChain[c] = '0;
    scramble = 1'b1;
    @(posedge clk); #1;
    scramble = 1'b0;
    patCount = CW'(pats);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (pats == 0) begin
      check(done == 1'b1, "R6 done after zero count", done, 1);
      check(signature == '0, "R6 signature after zero count", signature, 0);
      sigOut = signature;
      return;
    end
    for (int k = 0; k < total; k++) begin
      int pass = k / (CL + 1);
      int pos = k % (CL + 1);
      bit shiftCyc = (pos < CL);
      bit load = (pass < pats);
      bit unload = (pass > 0);
      logic [NC-1:0] exIn = (shiftCyc && load) ? phaseOf(rl) : '0;
      logic [NC-1:0] outs;
      if (k == glitchAt) begin
        patCount = '0;
        start = 1'b1;
      end
      if (scanEn !== shiftCyc && enOk) begin enOk = 0; enA = 64'(scanEn); enE = 64'(shiftCyc); end
      if (load && chainIn !== exIn && ldOk) begin ldOk = 0; ldA = 64'(chainIn); ldE = 64'(exIn); end
      if (!load && chainIn !== '0 && flOk) begin flOk = 0; flA = 64'(chainIn); end
      if (done !== 1'b0 && dnOk) begin dnOk = 0; dnAt = k; end
      if (shiftCyc) begin
        for (int c = 0; c < NC; c++) outs[c] = refChain[c][CL-1];
        if (unload) rm = misrAdv(rm, outs);
        for (int c = 0; c < NC; c++) refChain[c] = {refChain[c][CL-2:0], exIn[c]};
        if (load) rl = lfsrAdv(rl);
      end else begin
        logic [CL-1:0] tmp [NC];
        for (int c = 0; c < NC; c++)
          tmp[c] = {refChain[c][CL-2:0], refChain[c][CL-1]} ^ refChain[(c + 1) % NC];
        for (int c = 0; c < NC; c++) refChain[c] = tmp[c];
      end
      @(posedge clk); #1;
      start = 1'b0;
    end
    check(enOk, "R2 scan-enable schedule", enA, enE);
    check(ldOk, "R3 phase-shifted chain inputs", ldA, ldE);
    check(flOk, "R7 drain pass inputs zero", flA, 0);
    check(dnOk, "R5 done early", 64'(dnAt), 64'(total));
    check(done == 1'b1, "R5 done at end", done, 1);
    check(signature == rm, "R4 final signature", signature, rm);
    sigOut = signature;
  endtask

  initial begin
    logic [NC-1:0] sA, sB, held;
    void'($urandom(32'd20240611));
    #1;
    check(scanEn == 1'b0, "R1 scan-enable at reset", scanEn, 0);
    check(done == 1'b0, "R1 done at reset", done, 0);
    check(signature == '0, "R1 signature at reset", signature, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(posedge clk); #1;

    runTest(1, -1, sA);
    runTest(2, -1, sA);
    runTest(0, -1, sB);
    runTest(3, -1, sA);

    // R10: hold while start low
    held = signature;
    repeat (6) @(posedge clk);
    #1;
    check(done == 1'b1 && signature == held, "R10 hold after done", signature, held);

    // R9: repeat with same count
    runTest(3, -1, sB);
    check(sA == sB, "R9 repeated signature", sB, sA);

    // R8: start pulse mid-run ignored (mid-shift and on the capture cycle)
    runTest(3, 57, sB);
    check(sA == sB, "R8 start ignored mid-shift", sB, sA);
    runTest(3, CL, sB);
    check(sA == sB, "R8 start ignored at capture", sB, sA);

    for (int i = 0; i < 4; i++) runTest(1 + int'($urandom % 8), -1, sA);
    runTest(64, -1, sA);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule